// File: doc/BRIEF.md
# Scalar Double-Precision Add Lane with Write Mask

This block adds two IEEE 754 double-precision numbers held in the low 64 bits of 128-bit vector operands and returns a 128-bit result one clock later. The upper 64 bits pass through from an operand chosen by the encoding form. The low 64 bits are either the sum or, under a one-bit write mask, the previous destination value or zero. The rounding mode comes from a global 2-bit control field. A per-operation override replaces it, but only when the second operand is a register.

In the three-operand form, the sum is `src1_i[63:0] + src2_i[63:0]` and the upper half is copied from `src1_i`. In the legacy two-operand form, the destination is also the first source. The sum is `dst_i[63:0] + src2_i[63:0]`, the upper half is kept from `dst_i`, and `src1_i` is ignored. In both forms a masked merge keeps `dst_i[63:0]`. The five exception flags come from the arithmetic whether or not the mask suppresses the write. Subnormals are handled in full, with no flush to zero.

Top module: `sd_add_lane`

## Requirements
- R1: One cycle after `valid_i`, result bits 63:0 hold the correctly rounded IEEE 754 binary64 sum of the two selected low operands. This holds when neither operand is NaN or infinity and the sum does not overflow.
- R2: Rounding code encoding is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero, and each is honoured.
- R3: `rc_ovr_i` sets the mode only when `rc_ovr_vld_i=1` and `src2_is_reg_i=1`. Otherwise `rc_glb_i` sets it.
- R4: With `three_op_i=1`, result bits 127:64 equal `src1_i[127:64]` and the first addend is `src1_i[63:0]`.
- R5: With `three_op_i=0`, the first addend is `dst_i[63:0]`, result bits 127:64 equal `dst_i[127:64]`, and `src1_i` has no effect on the result.
- R6: When `mask_en_i=0` or `mask_bit_i=1`, bits 63:0 take the sum. When `mask_en_i=1` and `mask_bit_i=0`, bits 63:0 take `dst_i[63:0]` if `zero_mode_i=0`, and all zeros if `zero_mode_i=1`.
- R7: A NaN input gives the first NaN operand with its quiet bit (bit 51) set. Adding infinities of opposite sign gives 0xFFF8000000000000. Either case sets invalid when it arises from a signalling NaN or from the infinity clash.
- R8: An exact zero sum of opposite-signed operands is +0, except under toward-minus-infinity rounding, where it is -0.
- R9: On overflow the result is infinity or the largest finite value, as the rounding mode and sign dictate, and the overflow and precision flags are set.
- R10: Subnormal inputs and results are exact binary64 values, not flushed. The denormal flag is set whenever either addend is subnormal.
- R11: `flags_o` bit 0 is invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow (inexact result that is subnormal after rounding), and bit 4 precision. The flags are produced the same way whatever the mask state.
- R12: `valid_o` is `valid_i` delayed by one cycle. With `valid_i=0`, the result and flags hold. After reset, `valid_o`, `result_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| three_op_i | input | 1 | 1: three-operand form, 0: legacy form |
| src1_i | input | 128 | First source (three-operand form) |
| src2_i | input | 128 | Second source, low 64 bits used |
| dst_i | input | 128 | Prior destination value |
| src2_is_reg_i | input | 1 | Second source is a register |
| mask_en_i | input | 1 | Write mask in use |
| mask_bit_i | input | 1 | Write mask bit for the low lane |
| zero_mode_i | input | 1 | 1: zero masked lane, 0: merge |
| rc_ovr_vld_i | input | 1 | Rounding override requested |
| rc_ovr_i | input | 2 | Override rounding code |
| rc_glb_i | input | 2 | Global rounding code |
| valid_o | output | 1 | Result strobe |
| result_o | output | 128 | Result vector |
| flags_o | output | 5 | Exception flags |

## Verification
The hardest cases to reach are the ones where rounding depends on bits shifted far below the significand. One is an exact halfway tie. Another is a subnormal addend whose only contribution is a sticky bit lost in a 1022-place alignment. The stimulus table reaches these with hand-chosen operand pairs whose expected encodings were worked out separately: 1.0 plus 2^-53 under every mode that separates them, and 1.0 plus the smallest subnormal under truncation. The same halfway operand pair is then reused with the mask suppressing the write, to show that the precision flag still appears.

// File: rtl/sd_add_pkg.sv
package sd_add_pkg;
  localparam int FP_W    = 64;
  localparam int VEC_W   = 2 * FP_W;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int GRS_W   = 3;
  localparam int EXT_W   = MANT_W + GRS_W;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic [FP_W-1:0] QNAN_DFLT = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_RNE = 2'b00,
    RM_RDN = 2'b01,
    RM_RUP = 2'b10,
    RM_RTZ = 2'b11
  } rmode_e;

  typedef struct packed {
    logic pe;
    logic ue;
    logic oe;
    logic de;
    logic ie;
  } fp_flags_t;
endpackage

// File: rtl/sd_rmode_sel.sv
module sd_rmode_sel
  import sd_add_pkg::*;
(
  input  logic       ovr_vld_i,
  input  logic       src2_reg_i,
  input  logic [1:0] ovr_i,
  input  logic [1:0] glb_i,
  output rmode_e     rm_o
);
  logic use_ovr;
  assign use_ovr = ovr_vld_i & src2_reg_i;
  assign rm_o    = rmode_e'(use_ovr ? ovr_i : glb_i);
endmodule

// File: rtl/sd_lane_merge.sv
module sd_lane_merge
  import sd_add_pkg::*;
(
  input  logic             three_op_i,
  input  logic [VEC_W-1:0] src1_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [FP_W-1:0]  sum_i,
  input  logic             mask_en_i,
  input  logic             mask_bit_i,
  input  logic             zero_mode_i,
  output logic [FP_W-1:0]  op_a_o,
  output logic [VEC_W-1:0] res_o
);
  logic [FP_W-1:0] hi_src, lo_val;
  logic            wr_lane;

  // legacy form: destination doubles as first source
  assign op_a_o  = three_op_i ? src1_i[FP_W-1:0] : dst_i[FP_W-1:0];
  assign hi_src  = three_op_i ? src1_i[VEC_W-1:FP_W] : dst_i[VEC_W-1:FP_W];
  assign wr_lane = ~mask_en_i | mask_bit_i;

  always_comb begin
    if (wr_lane)          lo_val = sum_i;
    else if (zero_mode_i) lo_val = '0;
    else                  lo_val = dst_i[FP_W-1:0];
  end

  assign res_o = {hi_src, lo_val};
endmodule

// File: rtl/sd_fp64_add.sv
module sd_fp64_add
  import sd_add_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  rmode_e          rm_i,
  output logic [FP_W-1:0] sum_o,
  output fp_flags_t       flags_o
);
  localparam int EW = EXP_W + 1;

  logic              sa, sb, sx, sy;
  logic [EXP_W-1:0]  ea, eb, ex, ey;
  logic [FRAC_W-1:0] fa, fb, fx, fy;
  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_sub, b_sub, swap, eff_sub;

  assign {sa, ea, fa} = a_i;
  assign {sb, eb, fb} = b_i;
  assign a_nan  = (ea == EXP_MAX[EXP_W-1:0]) && (fa != '0);
  assign b_nan  = (eb == EXP_MAX[EXP_W-1:0]) && (fb != '0);
  assign a_snan = a_nan & ~fa[FRAC_W-1];
  assign b_snan = b_nan & ~fb[FRAC_W-1];
  assign a_inf  = (ea == EXP_MAX[EXP_W-1:0]) && (fa == '0);
  assign b_inf  = (eb == EXP_MAX[EXP_W-1:0]) && (fb == '0);
  assign a_sub  = (ea == '0) && (fa != '0);
  assign b_sub  = (eb == '0) && (fb != '0);

  // order by magnitude so the difference is never negative
  assign swap = {ea, fa} < {eb, fb};
  assign {sx, ex, fx} = swap ? b_i : a_i;
  assign {sy, ey, fy} = swap ? a_i : b_i;
  assign eff_sub = sx ^ sy;

  logic [EW-1:0]    ex_eff, ey_eff, dlt;
  logic [EXT_W-1:0] mx, my, my_al, lost_mask;
  logic             lost;

  assign ex_eff = (ex == '0) ? EW'(1) : {1'b0, ex};
  assign ey_eff = (ey == '0) ? EW'(1) : {1'b0, ey};
  assign dlt    = ex_eff - ey_eff;
  assign mx     = {ex != '0, fx, {GRS_W{1'b0}}};
  assign my     = {ey != '0, fy, {GRS_W{1'b0}}};

  always_comb begin
    if (dlt >= EW'(EXT_W)) begin
      lost_mask = '1;
      my_al     = '0;
    end else begin
      lost_mask = ~({EXT_W{1'b1}} << dlt);
      my_al     = my >> dlt;
    end
    lost = |(my & lost_mask);
  end

  logic [EXT_W:0]   sum_w;
  logic [EXT_W-1:0] m_pre, m_norm;
  logic [EW-1:0]    e_pre, e_norm, lz, sh;

  assign sum_w = eff_sub ? ({1'b0, mx} - {1'b0, my_al[EXT_W-1:1], my_al[0] | lost})
                         : ({1'b0, mx} + {1'b0, my_al[EXT_W-1:1], my_al[0] | lost});

  always_comb begin
    if (sum_w[EXT_W]) begin
      m_pre = {sum_w[EXT_W:2], |sum_w[1:0]};
      e_pre = ex_eff + EW'(1);
    end else begin
      m_pre = sum_w[EXT_W-1:0];
      e_pre = ex_eff;
    end
  end

  always_comb begin
    lz = EW'(EXT_W);
    for (int i = 0; i < EXT_W; i++) begin
      if (m_pre[i]) lz = EW'(EXT_W - 1 - i);
    end
  end

  // stop at the minimum exponent: leaves a subnormal significand
  assign sh     = (lz > e_pre - EW'(1)) ? e_pre - EW'(1) : lz;
  assign m_norm = m_pre << sh;
  assign e_norm = e_pre - sh;

  logic [MANT_W-1:0] mant, mant_r;
  logic [MANT_W:0]   mant_inc;
  logic [EW-1:0]     e_r;
  logic              g_bit, s_bit, inexact, inc, ovf, to_inf, zero_res, zsign;

  assign mant    = m_norm[EXT_W-1:GRS_W];
  assign g_bit   = m_norm[GRS_W-1];
  assign s_bit   = |m_norm[GRS_W-2:0];
  assign inexact = g_bit | s_bit;

  always_comb begin
    unique case (rm_i)
      RM_RNE:  inc = g_bit & (s_bit | mant[0]);
      RM_RDN:  inc = inexact & sx;
      RM_RUP:  inc = inexact & ~sx;
      default: inc = 1'b0;
    endcase
  end

  assign mant_inc = {1'b0, mant} + (MANT_W + 1)'(inc);
  assign mant_r   = mant_inc[MANT_W] ? mant_inc[MANT_W:1] : mant_inc[MANT_W-1:0];
  assign e_r      = mant_inc[MANT_W] ? e_norm + EW'(1) : e_norm;
  assign ovf      = mant_r[MANT_W-1] && (e_r >= EW'(EXP_MAX));
  assign to_inf   = (rm_i == RM_RNE) || (rm_i == RM_RUP && !sx) || (rm_i == RM_RDN && sx);
  assign zero_res = (m_pre == '0);
  assign zsign    = eff_sub ? (rm_i == RM_RDN) : sx;

  always_comb begin
    flags_o    = '0;
    flags_o.de = a_sub | b_sub;
    if (a_nan | b_nan) begin
      flags_o.ie = a_snan | b_snan;
      sum_o      = a_nan ? (a_i | (FP_W'(1) << (FRAC_W - 1))) : (b_i | (FP_W'(1) << (FRAC_W - 1)));
    end else if (a_inf & b_inf & (sa ^ sb)) begin
      flags_o.ie = 1'b1;
      sum_o      = QNAN_DFLT;
    end else if (a_inf) begin
      sum_o = a_i;
    end else if (b_inf) begin
      sum_o = b_i;
    end else if (zero_res) begin
      sum_o = {zsign, {(FP_W-1){1'b0}}};
    end else if (ovf) begin
      flags_o.oe = 1'b1;
      flags_o.pe = 1'b1;
      sum_o = to_inf ? {sx, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                     : {sx, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else begin
      flags_o.pe = inexact;
      flags_o.ue = inexact & ~mant_r[MANT_W-1];
      sum_o = {sx, mant_r[MANT_W-1] ? e_r[EXP_W-1:0] : {EXP_W{1'b0}}, mant_r[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/sd_add_lane.sv
module sd_add_lane
  import sd_add_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         three_op_i,
  input  logic [127:0] src1_i,
  input  logic [127:0] src2_i,
  input  logic [127:0] dst_i,
  input  logic         src2_is_reg_i,
  input  logic         mask_en_i,
  input  logic         mask_bit_i,
  input  logic         zero_mode_i,
  input  logic         rc_ovr_vld_i,
  input  logic [1:0]   rc_ovr_i,
  input  logic [1:0]   rc_glb_i,
  output logic         valid_o,
  output logic [127:0] result_o,
  output logic [4:0]   flags_o
);
  rmode_e           rm;
  logic [FP_W-1:0]  op_a, sum;
  logic [VEC_W-1:0] res_d;
  fp_flags_t        flg_d;
  logic             unused_src2_hi;

  assign unused_src2_hi = ^src2_i[VEC_W-1:FP_W];

  sd_rmode_sel u_rmode (
    .ovr_vld_i (rc_ovr_vld_i),
    .src2_reg_i(src2_is_reg_i),
    .ovr_i     (rc_ovr_i),
    .glb_i     (rc_glb_i),
    .rm_o      (rm)
  );

  sd_fp64_add u_add (
    .a_i    (op_a),
    .b_i    (src2_i[FP_W-1:0]),
    .rm_i   (rm),
    .sum_o  (sum),
    .flags_o(flg_d)
  );

  sd_lane_merge u_merge (
    .three_op_i (three_op_i),
    .src1_i     (src1_i),
    .dst_i      (dst_i),
    .sum_i      (sum),
    .mask_en_i  (mask_en_i),
    .mask_bit_i (mask_bit_i),
    .zero_mode_i(zero_mode_i),
    .op_a_o     (op_a),
    .res_o      (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        flags_o  <= flg_d;
      end
    end
  end

  p_valid_lat_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(flags_o)));
  p_upper_3op_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && three_op_i) |=> result_o[127:64] == $past(src1_i[127:64]));
  p_upper_leg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !three_op_i) |=> result_o[127:64] == $past(dst_i[127:64]));
  p_zero_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && !mask_bit_i && zero_mode_i) |=> result_o[63:0] == '0);
  p_merge_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && !mask_bit_i && !zero_mode_i) |=> result_o[63:0] == $past(dst_i[63:0]));
  p_invalid_nan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mask_en_i) |=> (!flags_o[0] || result_o[62:51] == 12'hFFF));
endmodule

// File: tb/sd_add_lane_tb_top.sv
`timescale 1ns/1ps
module sd_add_lane_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         valid_i = 0, three_op = 1, src2_reg = 1, mask_en = 0, mask_bit = 0, zmode = 0, ovr_vld = 0;
  logic [1:0]   ovr = 0, glb = 0;
  logic [127:0] src1 = 0, src2 = 0, dst = 0;
  logic         valid_o;
  logic [127:0] result_o;
  logic [4:0]   flags_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sd_add_lane dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .three_op_i(three_op),
    .src1_i(src1), .src2_i(src2), .dst_i(dst), .src2_is_reg_i(src2_reg),
    .mask_en_i(mask_en), .mask_bit_i(mask_bit), .zero_mode_i(zmode),
    .rc_ovr_vld_i(ovr_vld), .rc_ovr_i(ovr), .rc_glb_i(glb),
    .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o)
  );

  localparam logic [63:0] HI1 = 64'hAAAA_0000_1111_2222;
  localparam logic [63:0] HI2 = 64'h5555_3333_4444_6666;
  localparam logic [63:0] HID = 64'hDDDD_7777_8888_9999;
  localparam logic [63:0] DLO = 64'h0123_4567_89AB_CDEF;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  rm;
    logic [63:0] res;
    logic [4:0]  flg;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{64'h3FF0000000000000, 64'h4000000000000000, 2'b00, 64'h4008000000000000, 5'h00, 4'd1},  // R1 1+2
    '{64'hBFF0000000000000, 64'h3FF8000000000000, 2'b00, 64'h3FE0000000000000, 5'h00, 4'd1},  // R1 -1+1.5
    '{64'h3FF0000000000000, 64'hBFF0000000000000, 2'b00, 64'h0000000000000000, 5'h00, 4'd8},  // R8
    '{64'h3FF0000000000000, 64'hBFF0000000000000, 2'b01, 64'h8000000000000000, 5'h00, 4'd8},  // R8 RDN
    '{64'h0000000000000000, 64'h8000000000000000, 2'b01, 64'h8000000000000000, 5'h00, 4'd8},  // R8 zeros
    '{64'h7FF0000000000000, 64'hFFF0000000000000, 2'b00, 64'hFFF8000000000000, 5'h01, 4'd7},  // R7 inf clash
    '{64'h7FF0000000000001, 64'h3FF0000000000000, 2'b00, 64'h7FF8000000000001, 5'h01, 4'd7},  // R7 sNaN
    '{64'h3FF0000000000000, 64'h7FF8000000000005, 2'b00, 64'h7FF8000000000005, 5'h00, 4'd7},  // R7 qNaN
    '{64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 2'b00, 64'h7FF0000000000000, 5'h14, 4'd9},  // R9 to inf
    '{64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 2'b11, 64'h7FEFFFFFFFFFFFFF, 5'h14, 4'd9},  // R9 to max
    '{64'h3FF0000000000000, 64'h3CA0000000000000, 2'b00, 64'h3FF0000000000000, 5'h10, 4'd2},  // R2 tie even
    '{64'h3FF0000000000000, 64'h3CA0000000000000, 2'b10, 64'h3FF0000000000001, 5'h10, 4'd2},  // R2 up
    '{64'hBFF0000000000000, 64'hBCA0000000000000, 2'b01, 64'hBFF0000000000001, 5'h10, 4'd2},  // R2 down
    '{64'h3FF0000000000000, 64'h0000000000000001, 2'b11, 64'h3FF0000000000000, 5'h12, 4'd10}, // R10 R11 sticky
    '{64'h000FFFFFFFFFFFFF, 64'h0000000000000001, 2'b00, 64'h0010000000000000, 5'h02, 4'd10}  // R10 to normal
  };

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    src1 = {HI1, a}; src2 = {HI2, b}; valid_i = 1;
    @(negedge clk);
    valid_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    dst = {HID, DLO};
    #12 ;
    // R12 reset state
    chk("R12 reset valid", {127'b0, valid_o}, 128'd0);
    chk("R12 reset result", result_o, 128'd0);
    chk("R12 reset flags", {123'b0, flags_o}, 128'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      glb = VEC[i].rm;
      op(VEC[i].a, VEC[i].b);
      total++;
      if (result_o !== {HI1, VEC[i].res} || flags_o !== VEC[i].flg || valid_o !== 1'b1) begin
        bad++;
        $display("FAIL R%0d vec %0d act=%h/%h exp=%h/%h", VEC[i].rq, i, result_o, flags_o,
                 {HI1, VEC[i].res}, VEC[i].flg);
      end
    end

    // R6 R11 merge: lane kept, flags still raised
    glb = 2'b00; mask_en = 1; mask_bit = 0; zmode = 0;
    op(64'h3FF0000000000000, 64'h3CA0000000000000);
    chk("R6 merge", result_o, {HI1, DLO});
    chk("R11 flags under mask", {123'b0, flags_o}, 128'h10);
    zmode = 1;
    op(64'h3FF0000000000000, 64'h3CA0000000000000);
    chk("R6 zero", result_o, {HI1, 64'h0});
    mask_bit = 1;
    op(64'h3FF0000000000000, 64'h4000000000000000);
    chk("R6 mask bit set", result_o, {HI1, 64'h4008000000000000});
    mask_en = 0; mask_bit = 0; zmode = 0;

    // R5 legacy: dst is first addend, src1 ignored
    three_op = 0; dst = {HID, 64'h3FF0000000000000};
    op(64'h7FF0000000000001, 64'h4000000000000000);
    chk("R5 legacy result", result_o, {HID, 64'h4008000000000000});
    chk("R5 legacy flags", {123'b0, flags_o}, 128'h0);
    three_op = 1; dst = {HID, DLO};

    // R3 override gating
    glb = 2'b00; ovr = 2'b10; ovr_vld = 1; src2_reg = 1;
    op(64'h3FF0000000000000, 64'h3CA0000000000000);
    chk("R3 override used", result_o, {HI1, 64'h3FF0000000000001});
    src2_reg = 0;
    op(64'h3FF0000000000000, 64'h3CA0000000000000);
    chk("R3 memory source ignores override", result_o, {HI1, 64'h3FF0000000000000});
    ovr_vld = 0; src2_reg = 1;
    op(64'h3FF0000000000000, 64'h3CA0000000000000);
    chk("R3 no override", result_o, {HI1, 64'h3FF0000000000000});

    // R12 hold while idle
    @(negedge clk);
    src1 = {HID, 64'h4000000000000000}; src2 = '1;
    @(negedge clk);
    chk("R12 idle valid", {127'b0, valid_o}, 128'd0);
    chk("R12 idle hold", result_o, {HI1, 64'h3FF0000000000000});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule